// File: doc/BRIEF.md
# Exception Control Register Unit

This block keeps the exception-control state of a 32-bit RISC core. The pipeline presents, each cycle, the memory access in its memory stage (valid, load or store, size, address, PC), the flags of the instruction in its execute stage (system call, breakpoint, arithmetic overflow, PC) and a vector of external interrupt lines. The unit checks the memory access for misalignment and picks the single exception that belongs to the oldest instruction. When an exception is taken, the unit records the cause code, the faulting PC and, for address errors, the faulting data address. It pushes the kernel/interrupt-enable stack in the status register and tells fetch to restart at the handler vector.

Software reads the four registers by number through a move-from port and writes the status register through a move-to port. A return-from-exception strobe pops the status stack. Register numbers: 8 holds the bad data address, 12 holds status, 13 holds cause, and 14 holds the exception PC. All other numbers read as zero.

Top module: `exc_ctrl_unit`

## Requirements
- R1: After a synchronous reset, registers 8, 12, 13 and 14 read 0 and `redirect_valid` is 0.
- R2: A memory-stage access is misaligned when `mem_size` is 1 (halfword) and address bit 0 is set, or when `mem_size` is 2 or 3 (word) and address bits [1:0] are nonzero. Byte accesses (size 0) are never misaligned. A misaligned access raises an address error.
- R3: On an address error, register 8 takes `mem_addr` and register 14 takes `mem_pc`. The cause code in bits [6:2] of register 13 becomes 4 for a load and 5 for a store.
- R4: A system call writes code 8, a breakpoint writes code 9 and an overflow writes code 12. Each of these writes `ex_pc` to register 14 and leaves register 8 unchanged.
- R5: Only one exception is recorded per cycle. A memory-stage address error beats every execute-stage request. Within the execute stage, system call beats breakpoint, breakpoint beats overflow, and any synchronous exception beats an interrupt.
- R6: An interrupt (code 0, register 14 takes `ex_pc`) is taken only when status bit 0 is 1 and some `irq[i]` is high with status bit 8+i set. Cause bits [8+i] show `irq[i]` as sampled at the previous clock edge.
- R7: Taking an exception sets status[5:0] to {status[3:0], 2'b00}. The other status bits are unchanged.
- R8: `rfe_en` sets status[5:0] to {status[5:4], status[5:2]}. If an exception is taken in the same cycle, the exception update wins and the return is ignored.
- R9: `redirect_valid` is 1 for exactly the cycle after an exception is taken, with `redirect_pc` = 0x80000080. Otherwise `redirect_pc` is 0.
- R10: A move-to writes only register 12, and only its bits [8+NIRQ-1:8] and [5:0]; the other status bits stay 0. Move-to writes to any other number are ignored. A status write is dropped when an exception or `rfe_en` occurs in the same cycle.
- R11: `mf_data` shows, one clock after `mf_num` is sampled, the register with that number as it stood before that edge. Unimplemented numbers read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mem_valid | input | 1 | Memory stage holds a load or store |
| mem_store | input | 1 | 1 = store, 0 = load |
| mem_size | input | 2 | 0 byte, 1 halfword, 2/3 word |
| mem_addr | input | XLEN | Data address of the access |
| mem_pc | input | XLEN | PC of the memory-stage instruction |
| ex_syscall | input | 1 | Execute stage holds a system call |
| ex_break | input | 1 | Execute stage holds a breakpoint |
| ex_ovf | input | 1 | Execute stage arithmetic overflow |
| ex_pc | input | XLEN | PC of the execute-stage instruction |
| irq | input | NIRQ | External interrupt lines |
| rfe_en | input | 1 | Return-from-exception strobe |
| mt_en | input | 1 | Move-to write enable |
| mt_num | input | 5 | Move-to register number |
| mt_data | input | XLEN | Move-to data |
| mf_num | input | 5 | Move-from register number |
| mf_data | output | XLEN | Registered move-from data |
| redirect_valid | output | 1 | Fetch must restart at the handler |
| redirect_pc | output | XLEN | Handler vector address |

## Verification
The hardest situations to reach are the collisions, where several exception sources and the status writers all act in the same cycle. Examples are a misaligned store alongside a system call, a breakpoint, an overflow and an enabled interrupt, or a return-from-exception that meets an exception or a move-to. Directed cycles set up each of these collisions explicitly, after first loading status with the interrupt enable and mask bits. A long seeded random run then raises every source at moderate rates, so that overlaps arise often. That run keeps rotating the move-from number, so every register update is observed against the bench model.

// File: rtl/exc_pkg.sv
package exc_pkg;
  typedef enum logic [4:0] {
    CODE_IRQ     = 5'd0,
    CODE_ADDR_LD = 5'd4,
    CODE_ADDR_ST = 5'd5,
    CODE_SYSCALL = 5'd8,
    CODE_BREAK   = 5'd9,
    CODE_OVFL    = 5'd12
  } exc_code_e;

  localparam logic [4:0] RN_BADADDR = 5'd8;
  localparam logic [4:0] RN_STATUS  = 5'd12;
  localparam logic [4:0] RN_CAUSE   = 5'd13;
  localparam logic [4:0] RN_EPC     = 5'd14;

  localparam logic [1:0] SZ_BYTE = 2'd0;
  localparam logic [1:0] SZ_HALF = 2'd1;

  localparam int IM_LO   = 8;  // interrupt mask / pending low bit
  localparam int CODE_LO = 2;  // cause code low bit
endpackage

// File: rtl/exc_align_chk.sv
module exc_align_chk
  import exc_pkg::*;
(
  input  logic       acc_valid,
  input  logic       acc_store,
  input  logic [1:0] acc_size,
  input  logic [1:0] acc_lsb,
  output logic       misaligned,
  output logic       err_store
);
  logic half_bad;
  logic word_bad;

  always_comb begin
    half_bad   = (acc_size == SZ_HALF) && acc_lsb[0];
    word_bad   = acc_size[1] && (acc_lsb != 2'b00);
    misaligned = acc_valid && (half_bad || word_bad);
    err_store  = acc_store;
  end
endmodule

// File: rtl/exc_prio.sv
module exc_prio
  import exc_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  logic            adr_err,
  input  logic            adr_store,
  input  logic [XLEN-1:0] mem_pc,
  input  logic            sys_req,
  input  logic            brk_req,
  input  logic            ovf_req,
  input  logic            irq_hit,
  input  logic [XLEN-1:0] ex_pc,
  output logic            take,
  output exc_code_e       code,
  output logic [XLEN-1:0] epc_val,
  output logic            is_addr
);
  always_comb begin
    take    = 1'b1;
    code    = CODE_IRQ;
    epc_val = ex_pc;
    is_addr = 1'b0;
    if (adr_err) begin
      is_addr = 1'b1;
      epc_val = mem_pc;
      code    = adr_store ? CODE_ADDR_ST : CODE_ADDR_LD;
    end else if (sys_req) begin
      code = CODE_SYSCALL;
    end else if (brk_req) begin
      code = CODE_BREAK;
    end else if (ovf_req) begin
      code = CODE_OVFL;
    end else if (irq_hit) begin
      code = CODE_IRQ;
    end else begin
      take = 1'b0;
    end
  end
endmodule

// File: rtl/exc_status_stack.sv
module exc_status_stack
  import exc_pkg::*;
#(
  parameter int XLEN = 32,
  parameter int NIRQ = 6
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            take,
  input  logic            rfe,
  input  logic            wr_en,
  input  logic [XLEN-1:0] wr_data,
  output logic [XLEN-1:0] status_q
);
  function automatic logic [XLEN-1:0] mk_mask();
    logic [XLEN-1:0] m;
    m = '0;
    for (int i = 0; i < 6; i++) m[i] = 1'b1;
    for (int i = 0; i < NIRQ; i++) m[IM_LO+i] = 1'b1;
    return m;
  endfunction

  localparam logic [XLEN-1:0] WMASK = mk_mask();

  always_ff @(posedge clk) begin
    if (rst) begin
      status_q <= '0;
    end else if (take) begin
      status_q[5:0] <= {status_q[3:0], 2'b00};
    end else if (rfe) begin
      status_q[5:0] <= {status_q[5:4], status_q[5:2]};
    end else if (wr_en) begin
      status_q <= wr_data & WMASK;
    end
  end
endmodule

// File: rtl/exc_ctrl_unit.sv
module exc_ctrl_unit
  import exc_pkg::*;
#(
  parameter int              XLEN = 32,
  parameter int              NIRQ = 6,
  parameter logic [XLEN-1:0] VEC  = 32'h8000_0080
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            mem_valid,
  input  logic            mem_store,
  input  logic [1:0]      mem_size,
  input  logic [XLEN-1:0] mem_addr,
  input  logic [XLEN-1:0] mem_pc,
  input  logic            ex_syscall,
  input  logic            ex_break,
  input  logic            ex_ovf,
  input  logic [XLEN-1:0] ex_pc,
  input  logic [NIRQ-1:0] irq,
  input  logic            rfe_en,
  input  logic            mt_en,
  input  logic [4:0]      mt_num,
  input  logic [XLEN-1:0] mt_data,
  input  logic [4:0]      mf_num,
  output logic [XLEN-1:0] mf_data,
  output logic            redirect_valid,
  output logic [XLEN-1:0] redirect_pc
);
  logic            adr_err, adr_store;
  logic            take, is_addr, irq_hit;
  exc_code_e       sel_code;
  logic [XLEN-1:0] sel_epc;
  logic [XLEN-1:0] status_q;
  logic [NIRQ-1:0] hit_vec;
  logic [4:0]      code_q;
  logic [NIRQ-1:0] pend_q;
  logic [XLEN-1:0] epc_q, bad_q, cause_rd;

  exc_align_chk u_align (
    .acc_valid (mem_valid),
    .acc_store (mem_store),
    .acc_size  (mem_size),
    .acc_lsb   (mem_addr[1:0]),
    .misaligned(adr_err),
    .err_store (adr_store)
  );

  for (genvar gi = 0; gi < NIRQ; gi++) begin : g_irq
    assign hit_vec[gi] = irq[gi] & status_q[IM_LO+gi];
  end
  assign irq_hit = status_q[0] & (|hit_vec);

  exc_prio #(.XLEN(XLEN)) u_prio (
    .adr_err  (adr_err),
    .adr_store(adr_store),
    .mem_pc   (mem_pc),
    .sys_req  (ex_syscall),
    .brk_req  (ex_break),
    .ovf_req  (ex_ovf),
    .irq_hit  (irq_hit),
    .ex_pc    (ex_pc),
    .take     (take),
    .code     (sel_code),
    .epc_val  (sel_epc),
    .is_addr  (is_addr)
  );

  exc_status_stack #(.XLEN(XLEN), .NIRQ(NIRQ)) u_status (
    .clk     (clk),
    .rst     (rst),
    .take    (take),
    .rfe     (rfe_en),
    .wr_en   (mt_en && (mt_num == RN_STATUS)),
    .wr_data (mt_data),
    .status_q(status_q)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      code_q <= '0;
      pend_q <= '0;
      epc_q  <= '0;
      bad_q  <= '0;
    end else begin
      pend_q <= irq;
      if (take) begin
        code_q <= sel_code;
        epc_q  <= sel_epc;
        if (is_addr) bad_q <= mem_addr;
      end
    end
  end

  always_comb begin
    cause_rd = '0;
    cause_rd[CODE_LO +: 5]  = code_q;
    cause_rd[IM_LO +: NIRQ] = pend_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mf_data        <= '0;
      redirect_valid <= 1'b0;
      redirect_pc    <= '0;
    end else begin
      redirect_valid <= take;
      redirect_pc    <= take ? VEC : '0;
      case (mf_num)
        RN_BADADDR: mf_data <= bad_q;
        RN_STATUS:  mf_data <= status_q;
        RN_CAUSE:   mf_data <= cause_rd;
        RN_EPC:     mf_data <= epc_q;
        default:    mf_data <= '0;
      endcase
    end
  end
endmodule

// File: rtl/exc_ctrl_unit_chk.sv
module exc_ctrl_unit_chk #(
  parameter int              XLEN = 32,
  parameter logic [XLEN-1:0] VEC  = 32'h8000_0080
) (
  input logic            clk,
  input logic            rst,
  input logic            rfe_en,
  input logic [XLEN-1:0] mem_addr,
  input logic [XLEN-1:0] mem_pc,
  input logic [XLEN-1:0] ex_pc,
  input logic [4:0]      mf_num,
  input logic [XLEN-1:0] mf_data,
  input logic            redirect_valid,
  input logic [XLEN-1:0] redirect_pc,
  input logic [XLEN-1:0] status_q,
  input logic [4:0]      code_q,
  input logic [XLEN-1:0] epc_q,
  input logic [XLEN-1:0] bad_q
);
  logic addr_code;
  assign addr_code = (code_q == 5'd4) || (code_q == 5'd5);

  // R9
  redir_vec_chk: assert property (@(posedge clk) disable iff (rst)
    redirect_valid |-> redirect_pc == VEC);
  // R9
  redir_idle_chk: assert property (@(posedge clk) disable iff (rst)
    !redirect_valid |-> redirect_pc == '0);
  // R7
  exc_push_chk: assert property (@(posedge clk) disable iff (rst)
    redirect_valid |-> status_q[5:0] == {$past(status_q[3:0]), 2'b00});
  // R8
  rfe_pop_chk: assert property (@(posedge clk) disable iff (rst)
    (!redirect_valid && $past(rfe_en) && !$past(rst)) |->
      status_q[5:0] == {$past(status_q[5:4]), $past(status_q[5:2])});
  // R3
  bad_addr_chk: assert property (@(posedge clk) disable iff (rst)
    (redirect_valid && addr_code) |-> bad_q == $past(mem_addr));
  // R4
  bad_keep_chk: assert property (@(posedge clk) disable iff (rst)
    (redirect_valid && !addr_code) |-> $stable(bad_q));
  // R4
  epc_src_chk: assert property (@(posedge clk) disable iff (rst)
    redirect_valid |-> epc_q == (addr_code ? $past(mem_pc) : $past(ex_pc)));
  // R11
  unimpl_rd_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(mf_num) != 5'd8 && $past(mf_num) != 5'd12 &&
     $past(mf_num) != 5'd13 && $past(mf_num) != 5'd14) |-> mf_data == '0);
endmodule

bind exc_ctrl_unit exc_ctrl_unit_chk #(.XLEN(XLEN), .VEC(VEC)) u_chk (
  .clk           (clk),
  .rst           (rst),
  .rfe_en        (rfe_en),
  .mem_addr      (mem_addr),
  .mem_pc        (mem_pc),
  .ex_pc         (ex_pc),
  .mf_num        (mf_num),
  .mf_data       (mf_data),
  .redirect_valid(redirect_valid),
  .redirect_pc   (redirect_pc),
  .status_q      (status_q),
  .code_q        (code_q),
  .epc_q         (epc_q),
  .bad_q         (bad_q)
);

// File: tb/test_exc_ctrl_unit.sv
module test_exc_ctrl_unit;
  localparam int XLEN = 32;
  localparam int NIRQ = 6;
  localparam logic [31:0] VEC = 32'h8000_0080;
  localparam logic [31:0] SMASK = 32'h0000_3F3F;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic mem_valid = 0, mem_store = 0;
  logic [1:0] mem_size = 0;
  logic [31:0] mem_addr = 0, mem_pc = 0, ex_pc = 0, mt_data = 0;
  logic ex_syscall = 0, ex_break = 0, ex_ovf = 0, rfe_en = 0, mt_en = 0;
  logic [NIRQ-1:0] irq = 0;
  logic [4:0] mt_num = 0, mf_num = 0;
  logic [31:0] mf_data, redirect_pc;
  logic redirect_valid;

  int nchk = 0;
  int nerr = 0;
  bit done = 0;

  logic [31:0] m_st, m_epc, m_bad;
  logic [4:0]  m_code;
  logic [NIRQ-1:0] m_pend;

  always #2 clk = ~clk;

  exc_ctrl_unit #(.XLEN(XLEN), .NIRQ(NIRQ), .VEC(VEC)) i_exc_ctrl_unit (
    .clk(clk), .rst(rst), .mem_valid(mem_valid), .mem_store(mem_store),
    .mem_size(mem_size), .mem_addr(mem_addr), .mem_pc(mem_pc),
    .ex_syscall(ex_syscall), .ex_break(ex_break), .ex_ovf(ex_ovf),
    .ex_pc(ex_pc), .irq(irq), .rfe_en(rfe_en), .mt_en(mt_en),
    .mt_num(mt_num), .mt_data(mt_data), .mf_num(mf_num), .mf_data(mf_data),
    .redirect_valid(redirect_valid), .redirect_pc(redirect_pc)
  );

  function automatic logic [31:0] model_read(input logic [4:0] n);
    logic [31:0] r;
    r = '0;
    case (n)
      5'd8:  r = m_bad;
      5'd12: r = m_st;
      5'd13: begin r[6:2] = m_code; r[8 +: NIRQ] = m_pend; end
      5'd14: r = m_epc;
      default: r = '0;
    endcase
    return r;
  endfunction

  task automatic model_step(output logic tk);
    logic mis, hit;
    mis = mem_valid && ((mem_size == 2'd1 && mem_addr[0]) ||
                        (mem_size >= 2'd2 && mem_addr[1:0] != 2'b00));
    hit = m_st[0] && ((irq & m_st[8 +: NIRQ]) != '0);
    tk = mis || ex_syscall || ex_break || ex_ovf || hit;
    if (mis) begin
      m_code = mem_store ? 5'd5 : 5'd4; m_epc = mem_pc; m_bad = mem_addr;
    end else if (ex_syscall) begin m_code = 5'd8;  m_epc = ex_pc;
    end else if (ex_break)   begin m_code = 5'd9;  m_epc = ex_pc;
    end else if (ex_ovf)     begin m_code = 5'd12; m_epc = ex_pc;
    end else if (hit)        begin m_code = 5'd0;  m_epc = ex_pc;
    end
    if (tk) m_st[5:0] = {m_st[3:0], 2'b00};
    else if (rfe_en) m_st[5:0] = {m_st[5:4], m_st[5:2]};
    else if (mt_en && mt_num == 5'd12) m_st = mt_data & SMASK;
    m_pend = irq;
  endtask

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic do_cycle(input string tag);
    logic [31:0] exp_rd;
    logic exp_tk;
    string t9, tr;
    exp_rd = model_read(mf_num);
    model_step(exp_tk);
    @(posedge clk); #1;
    t9 = (tag == "") ? "R9" : tag;
    chk({t9, " redirect_valid"}, {31'd0, redirect_valid}, {31'd0, exp_tk});
    chk({t9, " redirect_pc"}, redirect_pc, exp_tk ? VEC : 32'd0);
    if (tag != "") tr = tag;
    else case (mf_num)
      5'd8: tr = "R3"; 5'd12: tr = "R7"; 5'd13, 5'd14: tr = "R4";
      default: tr = "R11";
    endcase
    chk({tr, " mf_data"}, mf_data, exp_rd);
    @(negedge clk);
  endtask

  task automatic idle();
    mem_valid = 0; mem_store = 0; mem_size = 0; mem_addr = 0; mem_pc = 0;
    ex_syscall = 0; ex_break = 0; ex_ovf = 0; ex_pc = 0; irq = 0;
    rfe_en = 0; mt_en = 0; mt_num = 0; mt_data = 0;
  endtask

  task automatic read_all(input string tag);
    idle();
    mf_num = 5'd8;  do_cycle(tag);
    mf_num = 5'd12; do_cycle(tag);
    mf_num = 5'd13; do_cycle(tag);
    mf_num = 5'd14; do_cycle(tag);
  endtask

  task automatic wr_status(input logic [31:0] v);
    idle(); mt_en = 1; mt_num = 5'd12; mt_data = v; do_cycle("R10");
  endtask

  initial begin
    #400000;
    if (!done) begin
      nerr++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", nchk, nerr);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    m_st = 0; m_epc = 0; m_bad = 0; m_code = 0; m_pend = 0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 0;

    // R1 reset state
    read_all("R1");

    // R10 writable status bits, other numbers ignored
    wr_status(32'hFFFF_FFFF);
    idle(); mt_en = 1; mt_num = 5'd8;  mt_data = 32'h1234_5678; do_cycle("R10");
    idle(); mt_en = 1; mt_num = 5'd13; mt_data = 32'hFFFF_FFFF; do_cycle("R10");
    idle(); mt_en = 1; mt_num = 5'd14; mt_data = 32'hDEAD_BEEF; do_cycle("R10");
    read_all("R10");

    // R6 interrupt taken with IE and mask set
    idle(); irq = 6'b000100; ex_pc = 32'h0040_0100; do_cycle("R6");
    read_all("R6");
    idle(); irq = 6'b111111; do_cycle("R6");         // IE now 0
    wr_status(32'h0000_0001);                        // IE=1, mask 0
    idle(); irq = 6'b111111; do_cycle("R6");
    wr_status(32'h0000_2001);                        // only line 5 enabled
    idle(); irq = 6'b011111; do_cycle("R6");
    idle(); irq = 6'b100000; ex_pc = 32'h0040_0200; do_cycle("R6");
    read_all("R6");

    // R2 alignment
    wr_status(32'h0);
    idle(); mem_valid = 1; mem_size = 2'd1; mem_addr = 32'h1000_0003; mem_pc = 32'h0040_0300; do_cycle("R2");
    read_all("R3");
    idle(); mem_valid = 1; mem_size = 2'd0; mem_addr = 32'h1000_0007; do_cycle("R2");
    idle(); mem_valid = 1; mem_size = 2'd1; mem_addr = 32'h1000_0006; do_cycle("R2");
    idle(); mem_valid = 1; mem_size = 2'd2; mem_addr = 32'h1000_0008; do_cycle("R2");
    idle(); mem_valid = 1; mem_size = 2'd3; mem_addr = 32'h1000_0001; do_cycle("R2");
    idle(); mem_valid = 1; mem_store = 1; mem_size = 2'd2; mem_addr = 32'h2000_0002; mem_pc = 32'h0040_0400; do_cycle("R2");
    read_all("R3");
    idle(); mem_valid = 0; mem_size = 2'd2; mem_addr = 32'h2000_0003; do_cycle("R2");

    // R5 priority
    wr_status(32'h0000_3F01);
    idle(); mem_valid = 1; mem_store = 1; mem_size = 2'd1; mem_addr = 32'h3000_0001;
    mem_pc = 32'h0040_0500; ex_pc = 32'h0040_0504; ex_syscall = 1; ex_break = 1;
    ex_ovf = 1; irq = 6'h3F; do_cycle("R5");
    read_all("R5");
    idle(); ex_syscall = 1; ex_break = 1; ex_ovf = 1; ex_pc = 32'h0040_0600; do_cycle("R5");
    read_all("R5");
    idle(); ex_break = 1; ex_ovf = 1; ex_pc = 32'h0040_0700; do_cycle("R5");
    read_all("R5");
    idle(); ex_ovf = 1; ex_pc = 32'h0040_0800; do_cycle("R4");
    read_all("R4");

    // R8 return from exception and collisions
    wr_status(32'h0000_002B);
    idle(); rfe_en = 1; do_cycle("R8");
    read_all("R8");
    idle(); rfe_en = 1; ex_syscall = 1; ex_pc = 32'h0040_0900; do_cycle("R8");
    read_all("R8");
    idle(); rfe_en = 1; mt_en = 1; mt_num = 5'd12; mt_data = 32'h0000_0015; do_cycle("R10");
    read_all("R10");
    idle(); mt_en = 1; mt_num = 5'd12; mt_data = 32'h0000_0015; ex_break = 1; do_cycle("R10");
    read_all("R10");
    idle(); mf_num = 5'd3;  do_cycle("R11");
    idle(); mf_num = 5'd31; do_cycle("R11");

    // random mix
    for (int i = 0; i < 4000; i++) begin
      logic [2:0] pick;
      idle();
      mem_valid  = ($urandom % 4) == 0;
      mem_store  = $urandom % 2;
      mem_size   = $urandom % 4;
      mem_addr   = $urandom;
      mem_pc     = $urandom & 32'hFFFF_FFFC;
      ex_pc      = $urandom & 32'hFFFF_FFFC;
      ex_syscall = ($urandom % 16) == 0;
      ex_break   = ($urandom % 16) == 0;
      ex_ovf     = ($urandom % 16) == 0;
      irq        = (($urandom % 4) == 0) ? NIRQ'($urandom) : '0;
      rfe_en     = ($urandom % 8) == 0;
      mt_en      = ($urandom % 4) == 0;
      pick       = 3'($urandom % 5);
      case (pick)
        3'd0: mt_num = 5'd8; 3'd1: mt_num = 5'd12; 3'd2: mt_num = 5'd13;
        3'd3: mt_num = 5'd14; default: mt_num = 5'($urandom);
      endcase
      mt_data    = $urandom;
      pick       = 3'($urandom % 5);
      case (pick)
        3'd0: mf_num = 5'd8; 3'd1: mf_num = 5'd12; 3'd2: mf_num = 5'd13;
        3'd3: mf_num = 5'd14; default: mf_num = 5'($urandom);
      endcase
      do_cycle("");
    end

    done = 1;
    $display("CHECKS %0d ERRORS %0d", nchk, nerr);
    $finish;
  end
endmodule